// File: doc/BRIEF.md
# Converter configuration word register

This block holds the 32-bit control word of a multi-channel data converter and turns it into decoded control fields: conversion clock source, clock-out enable, flag mode and flag polarity, standby, a range select for each of four channel pairs (A to D), a power-down for pairs B, C and D, reference enable, reference buffer disable, reference voltage select and a 10-bit reference DAC code. The word is loaded either over a 16-bit parallel bus as two write strobes (upper half first) or shifted in MSB first during a 32-clock serial frame. A write only lands when bit 31 of the written word is 1 and the block is in software mode.

Setting bit 30 in a landed write arms a read-back: the next two serial frames present the stored word, MSB first, on a dedicated serial output instead of conversion data, after which bit 30 clears itself. In hardware mode the register cannot be written and keeps its contents, while some outputs follow pins instead of the stored bits. A conversion start that arrives between the two parallel strobes discards the half-written pair and sets a sticky error flag. The DAC code output never falls below 204.

All inputs are synchronous to `clk`; strobe, frame and serial-clock edges are found by comparing each input with its value one cycle earlier. The parallel receiver has states P_IDLE and P_HALF: P_IDLE goes to P_HALF on a strobe rising edge (upper half captured); P_HALF goes back to P_IDLE either on the second strobe rising edge (word delivered) or on a conversion start (pair discarded, error set). The serial receiver has states S_IDLE, S_SHIFT and S_WAIT: S_IDLE goes to S_SHIFT on a frame falling edge (bit count cleared, read-back access claimed if one is pending); S_SHIFT goes to S_WAIT on the 32nd serial-clock falling edge (word delivered) or back to S_IDLE if the frame ends early (nothing delivered); S_WAIT goes to S_IDLE when the frame ends.

Top module: `cfg_word_reg`

## Requirements
- R1: After reset the stored word is 0x000003FF: dac_code reads 0x3FF, every other decoded output, rb_active, cfg_sdo and abort_err read 0.
- R2: With ser_sel=0, two rising edges of wr_stb load {first wr_data, second wr_data}; outputs change only after the second edge. Bit positions of the word: 29 clock select, 28 clock out, 27 flag mode, 26 flag polarity, 25 standby, 24/23/21/19 range for pairs A/B/C/D (range_half bits 0..3), 22/20/18 power-down for pairs B/C/D (pd_pair bits 0..2), 15 reference enable, 14 reference buffer disable, 13 reference voltage select, 9:0 DAC code.
- R3: With ser_sel=1, while frame_n is low sdi is taken MSB first on each sclk falling edge and the word is applied on the 32nd falling edge; a frame that ends before 32 edges changes nothing.
- R4: A written word with bit 31 = 0 leaves every output unchanged.
- R5: A landed write with bit 30 = 1 makes the next two serial frames assert rb_active and shift the stored word out on cfg_sdo MSB first (bit 31-k during the k-th sclk high phase); bit 30 reads 1 in the first of them and 0 in the second; the third frame is a normal one.
- R6: With sw_mode=0 no write of either kind changes the stored word, and the contents are unchanged when sw_mode returns to 1.
- R7: With sw_mode=0, clk_out_en is 0, standby follows hw_stby, every range_half bit follows hw_range, ref_en follows hw_refen, ref_buf_off is bit 14 only when ser_sel=0 (else 0); clock select, flag mode, flag polarity, power-downs, voltage select and DAC code still follow the stored word.
- R8: A conv_start while the first half of a parallel pair is held discards the pair and sets abort_err, which stays set until reset; a conv_start in the same cycle as the second strobe edge does not abort, and the word is applied.
- R9: dac_code is the stored code, raised to 204 when the stored code is below 204.
- R10: Stored bits 31, 17:16 and 12:10 always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset to the default word |
| sw_mode | input | 1 | 1 = software mode (writable), 0 = hardware mode |
| ser_sel | input | 1 | 1 = serial interface, 0 = parallel interface |
| hw_range | input | 1 | Range pin used by all pairs in hardware mode |
| hw_stby | input | 1 | Standby pin used in hardware mode |
| hw_refen | input | 1 | Reference-enable pin used in hardware mode |
| conv_start | input | 1 | Conversion start pulse |
| wr_stb | input | 1 | Parallel write strobe |
| wr_data | input | 16 | Parallel write data |
| frame_n | input | 1 | Serial frame, active low |
| sclk | input | 1 | Serial clock (sampled) |
| sdi | input | 1 | Serial data in |
| clk_sel | output | 1 | External conversion clock select |
| clk_out_en | output | 1 | Internal clock output enable |
| flag_int_mode | output | 1 | Flag pin in interrupt mode |
| flag_active_low | output | 1 | Flag polarity |
| standby | output | 1 | Whole-device power-down |
| range_half | output | 4 | Half-range select, pairs A..D |
| pd_pair | output | 3 | Power-down, pairs B..D |
| ref_en | output | 1 | Internal reference enable |
| ref_buf_off | output | 1 | Reference buffers disabled |
| vref_hi | output | 1 | Higher reference voltage select |
| dac_code | output | 10 | Clamped reference DAC code |
| rb_active | output | 1 | Current serial frame is a read-back |
| cfg_sdo | output | 1 | Read-back serial data |
| abort_err | output | 1 | Sticky aborted-pair flag |

## Verification
The two events that can coincide are the second parallel strobe edge, which completes a word, and a conversion start, which discards a half-written pair. The bench drives conv_start high on the very cycle the second strobe rises and then requires that the new word reaches the outputs and abort_err stays 0. A separate scenario puts the conversion start one cycle before the second strobe and requires the old outputs to survive and abort_err to rise and stay up.

// File: rtl/cfgreg_pkg.sv
`timescale 1ns/1ps
package cfgreg_pkg;
    localparam int CW      = 32;
    localparam int HW      = 16;
    localparam int PAIRS   = 4;
    localparam int DAC_W   = 10;

    localparam int BIT_WEN     = 31;
    localparam int BIT_RBK     = 30;
    localparam int BIT_CLKSEL  = 29;
    localparam int BIT_CLKOUT  = 28;
    localparam int BIT_FMODE   = 27;
    localparam int BIT_FPOL    = 26;
    localparam int BIT_STBY    = 25;
    localparam int BIT_REFEN   = 15;
    localparam int BIT_REFBUF  = 14;
    localparam int BIT_VREF    = 13;

    localparam logic [CW-1:0] CFG_RESET = 32'h0000_03FF;
    // bits that are stored; 31, 30 (held apart), 17:16 and 12:10 are not
    localparam logic [CW-1:0] CFG_KEEP  = 32'h3FFC_E3FF;

    function automatic int range_pos(input int pair);
        case (pair)
            0:       return 24;
            1:       return 23;
            2:       return 21;
            default: return 19;
        endcase
    endfunction

    // power-down exists for pairs B, C, D only (index 0 = B)
    function automatic int pd_pos(input int idx);
        case (idx)
            0:       return 22;
            1:       return 20;
            default: return 18;
        endcase
    endfunction

    typedef enum logic {P_IDLE, P_HALF} par_state_t;
    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_WAIT} ser_state_t;
endpackage

// File: rtl/cfg_par_rx.sv
`timescale 1ns/1ps
module cfg_par_rx
    import cfgreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr_stb,
    input  logic [HW-1:0] wr_data,
    input  logic          conv_start,
    output logic          word_valid,
    output logic [CW-1:0] word,
    output logic          abort_err
);
    par_state_t    state_q, state_d;
    logic          stb_q;
    logic [HW-1:0] upper_q;
    logic          err_q;
    logic          stb_rise;
    logic          set_err;
    logic          take_upper;

    assign stb_rise = enable & wr_stb & ~stb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        word_valid = 1'b0;
        set_err    = 1'b0;
        take_upper = 1'b0;
        unique case (state_q)
            P_IDLE: begin
                if (stb_rise) begin
                    take_upper = 1'b1;
                    state_d    = P_HALF;
                end
            end
            P_HALF: begin
                if (stb_rise) begin
                    word_valid = 1'b1;
                    state_d    = P_IDLE;
                end else if (conv_start) begin
                    set_err = 1'b1;
                    state_d = P_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            upper_q <= '0;
            err_q   <= 1'b0;
        end else begin
            stb_q <= wr_stb;
            if (take_upper) upper_q <= wr_data;
            if (set_err)    err_q   <= 1'b1;
        end
    end

    assign word      = {upper_q, wr_data};
    assign abort_err = err_q;

    assert_abort_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_HALF && conv_start && !stb_rise) |=> abort_err);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |=> abort_err);
    assert_word_needs_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> state_q == P_HALF);
endmodule

// File: rtl/cfg_ser_rx.sv
`timescale 1ns/1ps
module cfg_ser_rx
    import cfgreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          frame_n,
    input  logic          sclk,
    input  logic          sdi,
    input  logic          rb_pending,
    input  logic [CW-1:0] rb_word,
    output logic          word_valid,
    output logic [CW-1:0] word,
    output logic          rb_take,
    output logic          rb_active,
    output logic          sdo
);
    localparam int CNT_W = $clog2(CW);

    ser_state_t     state_q, state_d;
    logic           frame_q, sclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CW-1:0]  shift_q;
    logic           rbact_q;
    logic           frame_fall, frame_rise, sclk_fall;
    logic           clr_cnt, inc_cnt, do_shift, end_frame;

    assign frame_fall = enable & frame_q & ~frame_n;
    assign frame_rise = ~frame_q & frame_n;
    assign sclk_fall  = sclk_q & ~sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        word_valid = 1'b0;
        rb_take    = 1'b0;
        clr_cnt    = 1'b0;
        inc_cnt    = 1'b0;
        do_shift   = 1'b0;
        end_frame  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (frame_fall) begin
                    clr_cnt = 1'b1;
                    rb_take = rb_pending;
                    state_d = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (frame_rise) begin
                    end_frame = 1'b1;
                    state_d   = S_IDLE;
                end else if (sclk_fall) begin
                    do_shift = 1'b1;
                    if (cnt_q == CNT_W'(CW-1)) begin
                        word_valid = 1'b1;
                        state_d    = S_WAIT;
                    end else begin
                        inc_cnt = 1'b1;
                    end
                end
            end
            S_WAIT: begin
                if (frame_rise) begin
                    end_frame = 1'b1;
                    state_d   = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            sclk_q  <= 1'b0;
            cnt_q   <= '0;
            shift_q <= '0;
            rbact_q <= 1'b0;
        end else begin
            frame_q <= frame_n;
            sclk_q  <= sclk;
            if (clr_cnt)       cnt_q <= '0;
            else if (inc_cnt)  cnt_q <= cnt_q + 1'b1;
            if (do_shift)      shift_q <= {shift_q[CW-2:0], sdi};
            if (rb_take)        rbact_q <= 1'b1;
            else if (end_frame) rbact_q <= 1'b0;
        end
    end

    assign word      = {shift_q[CW-2:0], sdi};
    assign rb_active = rbact_q;
    assign sdo       = rbact_q & rb_word[CNT_W'(CW-1) - cnt_q];

    assert_single_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    assert_word_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !frame_n);
endmodule

// File: rtl/cfg_field_map.sv
`timescale 1ns/1ps
module cfg_field_map
    import cfgreg_pkg::*;
#(
    parameter int DAC_MIN = 204
) (
    input  logic             sw_mode,
    input  logic             ser_sel,
    input  logic             hw_range,
    input  logic             hw_stby,
    input  logic             hw_refen,
    input  logic [CW-1:0]    word,
    output logic             clk_sel,
    output logic             clk_out_en,
    output logic             flag_int_mode,
    output logic             flag_active_low,
    output logic             standby,
    output logic [PAIRS-1:0] range_half,
    output logic [PAIRS-2:0] pd_pair,
    output logic             ref_en,
    output logic             ref_buf_off,
    output logic             vref_hi,
    output logic [DAC_W-1:0] dac_code
);
    logic [DAC_W-1:0] raw_code;

    assign raw_code = word[DAC_W-1:0];

    always_comb begin
        clk_sel         = word[BIT_CLKSEL];
        clk_out_en      = sw_mode & word[BIT_CLKOUT];
        flag_int_mode   = word[BIT_FMODE];
        flag_active_low = word[BIT_FPOL];
        standby         = sw_mode ? word[BIT_STBY]  : hw_stby;
        ref_en          = sw_mode ? word[BIT_REFEN] : hw_refen;
        ref_buf_off     = (sw_mode | ~ser_sel) & word[BIT_REFBUF];
        vref_hi         = word[BIT_VREF];
        dac_code        = (raw_code < DAC_W'(DAC_MIN)) ? DAC_W'(DAC_MIN) : raw_code;
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_range
        assign range_half[p] = sw_mode ? word[range_pos(p)] : hw_range;
    end

    for (genvar q = 0; q < PAIRS-1; q++) begin : g_pd
        assign pd_pair[q] = word[pd_pos(q)];
    end
endmodule

// File: rtl/cfg_word_reg.sv
`timescale 1ns/1ps
module cfg_word_reg
    import cfgreg_pkg::*;
#(
    parameter int DAC_MIN  = 204,
    parameter int RB_COUNT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_mode,
    input  logic             ser_sel,
    input  logic             hw_range,
    input  logic             hw_stby,
    input  logic             hw_refen,
    input  logic             conv_start,
    input  logic             wr_stb,
    input  logic [HW-1:0]    wr_data,
    input  logic             frame_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             clk_sel,
    output logic             clk_out_en,
    output logic             flag_int_mode,
    output logic             flag_active_low,
    output logic             standby,
    output logic [PAIRS-1:0] range_half,
    output logic [PAIRS-2:0] pd_pair,
    output logic             ref_en,
    output logic             ref_buf_off,
    output logic             vref_hi,
    output logic [DAC_W-1:0] dac_code,
    output logic             rb_active,
    output logic             cfg_sdo,
    output logic             abort_err
);
    localparam int RB_W = $clog2(RB_COUNT + 1);

    logic [CW-1:0]   body_q;
    logic [RB_W-1:0] rb_left_q;
    logic [CW-1:0]   cur_word;
    logic            par_valid, ser_valid;
    logic [CW-1:0]   par_word, ser_word, new_word;
    logic            rb_take, rb_pending, wr_ok;

    assign rb_pending = (rb_left_q != '0);
    assign cur_word   = body_q | ({{(CW-1){1'b0}}, rb_pending} << BIT_RBK);
    assign new_word   = ser_sel ? ser_word : par_word;
    assign wr_ok      = (par_valid | ser_valid) & sw_mode & new_word[BIT_WEN];

    cfg_par_rx u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (~ser_sel),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .conv_start (conv_start),
        .word_valid (par_valid),
        .word       (par_word),
        .abort_err  (abort_err)
    );

    cfg_ser_rx u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ser_sel),
        .frame_n    (frame_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .rb_pending (rb_pending),
        .rb_word    (cur_word),
        .word_valid (ser_valid),
        .word       (ser_word),
        .rb_take    (rb_take),
        .rb_active  (rb_active),
        .sdo        (cfg_sdo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q    <= CFG_RESET & CFG_KEEP;
            rb_left_q <= '0;
        end else begin
            if (wr_ok) begin
                body_q    <= new_word & CFG_KEEP;
                rb_left_q <= new_word[BIT_RBK] ? RB_W'(RB_COUNT) : '0;
            end else if (rb_take) begin
                rb_left_q <= rb_left_q - 1'b1;
            end
        end
    end

    cfg_field_map #(.DAC_MIN(DAC_MIN)) u_map (
        .sw_mode         (sw_mode),
        .ser_sel         (ser_sel),
        .hw_range        (hw_range),
        .hw_stby         (hw_stby),
        .hw_refen        (hw_refen),
        .word            (cur_word),
        .clk_sel         (clk_sel),
        .clk_out_en      (clk_out_en),
        .flag_int_mode   (flag_int_mode),
        .flag_active_low (flag_active_low),
        .standby         (standby),
        .range_half      (range_half),
        .pd_pair         (pd_pair),
        .ref_en          (ref_en),
        .ref_buf_off     (ref_buf_off),
        .vref_hi         (vref_hi),
        .dac_code        (dac_code)
    );

    assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({par_valid, ser_valid}));
    assert_no_wen_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((par_valid || ser_valid) && !new_word[BIT_WEN]) |=> $stable(body_q));
    assert_hw_mode_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_mode |=> $stable(body_q));
    assert_rb_take_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rb_take |-> rb_pending);
    assert_dac_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code >= DAC_W'(DAC_MIN));
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_word[31] == 1'b0) && (cur_word[17:16] == 2'b00) && (cur_word[12:10] == 3'b000));
endmodule

// File: tb/cfg_word_reg_tb.sv
`timescale 1ns/1ps
module cfg_word_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_mode = 1'b1, ser_sel = 1'b0;
    logic        hw_range = 1'b0, hw_stby = 1'b0, hw_refen = 1'b0;
    logic        conv_start = 1'b0, wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic        clk_sel, clk_out_en, flag_int_mode, flag_active_low, standby;
    logic [3:0]  range_half;
    logic [2:0]  pd_pair;
    logic        ref_en, ref_buf_off, vref_hi;
    logic [9:0]  dac_code;
    logic        rb_active, cfg_sdo, abort_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cfg_word_reg u_dut (
        .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .ser_sel(ser_sel),
        .hw_range(hw_range), .hw_stby(hw_stby), .hw_refen(hw_refen),
        .conv_start(conv_start), .wr_stb(wr_stb), .wr_data(wr_data),
        .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
        .clk_sel(clk_sel), .clk_out_en(clk_out_en), .flag_int_mode(flag_int_mode),
        .flag_active_low(flag_active_low), .standby(standby), .range_half(range_half),
        .pd_pair(pd_pair), .ref_en(ref_en), .ref_buf_off(ref_buf_off), .vref_hi(vref_hi),
        .dac_code(dac_code), .rb_active(rb_active), .cfg_sdo(cfg_sdo), .abort_err(abort_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // packs decoded outputs: {clk_sel,clk_out,fmode,fpol,stby,range[3:0],pd[2:0],ref_en,buf_off,vref,dac}
    function automatic logic [31:0] outs();
        return {7'd0, clk_sel, clk_out_en, flag_int_mode, flag_active_low, standby,
                range_half, pd_pair, ref_en, ref_buf_off, vref_hi, dac_code};
    endfunction

    function automatic logic [31:0] pack(input logic cs, co, fm, fp, sb, input logic [3:0] rg,
                                         input logic [2:0] pd, input logic re, rb, vh,
                                         input logic [9:0] dac);
        return {7'd0, cs, co, fm, fp, sb, rg, pd, re, rb, vh, dac};
    endfunction

    task automatic strobe(input logic [15:0] d);
        @(negedge clk) wr_data = d; wr_stb = 1'b1;
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic par_write(input logic [31:0] w);
        strobe(w[31:16]);
        strobe(w[15:0]);
        @(negedge clk);
    endtask

    task automatic ser_access(input logic [31:0] w, input int nbits,
                              output logic [31:0] got, output logic rb_seen);
        got = '0;
        rb_seen = 1'b0;
        @(negedge clk) frame_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[31-i]; sclk = 1'b1;
            @(negedge clk);
            got[31-i] = cfg_sdo;
            rb_seen   = rb_seen | rb_active;
            sclk = 1'b0;
            @(negedge clk);
        end
        frame_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 outputs after reset", outs(), pack(0,0,0,0,0,4'h0,3'h0,0,0,0,10'h3FF));
        chk("R1 rb_active/sdo/err", {29'd0, rb_active, cfg_sdo, abort_err}, 32'd0);
    endtask

    task automatic t_parallel();
        strobe(16'hA530);
        @(negedge clk);
        chk("R2 no change after first half", outs(), pack(0,0,0,0,0,4'h0,3'h0,0,0,0,10'h3FF));
        strobe(16'hA155);
        @(negedge clk);
        chk("R2 word applied on second strobe", outs(),
            pack(1,0,0,1,0,4'b0101,3'b010,1,0,1,10'h155));
    endtask

    task automatic t_no_wen();
        par_write(32'h1000_00CC);
        chk("R4 bit31 clear ignored", outs(),
            pack(1,0,0,1,0,4'b0101,3'b010,1,0,1,10'h155));
    endtask

    task automatic t_serial();
        logic [31:0] g; logic r;
        ser_sel = 1'b1;
        ser_access(32'h8A00_4100, 31, g, r);
        chk("R3 short frame ignored", outs(),
            pack(1,0,0,1,0,4'b0101,3'b010,1,0,1,10'h155));
        ser_access(32'h8A00_4100, 32, g, r);
        chk("R3 serial word applied", outs(),
            pack(0,0,1,0,1,4'h0,3'h0,0,1,0,10'h100));
        chk("R3 no readback", {31'd0, r}, 32'd0);
    endtask

    task automatic t_readback();
        logic [31:0] g; logic r;
        ser_access(32'hFFFF_FFFF, 32, g, r);
        ser_access(32'h0, 32, g, r);
        chk("R5 first readback active", {31'd0, r}, 32'd1);
        chk("R5 R10 first readback word", g, 32'h7FFC_E3FF);
        ser_access(32'h0, 32, g, r);
        chk("R5 second readback active", {31'd0, r}, 32'd1);
        chk("R5 R10 second readback word", g, 32'h3FFC_E3FF);
        ser_access(32'h0, 32, g, r);
        chk("R5 third frame normal", {r, g[31:1]}, 32'd0);
    endtask

    task automatic t_hw_mode();
        @(negedge clk) sw_mode = 1'b0;
        @(negedge clk);
        chk("R7 hw serial masking", outs(), pack(1,0,1,1,0,4'h0,3'b111,0,0,1,10'h3FF));
        ser_sel = 1'b0; hw_range = 1'b1; hw_stby = 1'b1; hw_refen = 1'b1;
        @(negedge clk);
        chk("R7 hw parallel pins", outs(), pack(1,0,1,1,1,4'hF,3'b111,1,1,1,10'h3FF));
        par_write(32'h8000_0000);
        chk("R6 hw parallel write ignored", {22'd0, dac_code}, 32'h3FF);
        hw_range = 1'b0; hw_stby = 1'b0; hw_refen = 1'b0;
        @(negedge clk) sw_mode = 1'b1;
        @(negedge clk);
        chk("R6 contents kept in sw mode", outs(), pack(1,1,1,1,1,4'hF,3'b111,1,1,1,10'h3FF));
    endtask

    task automatic t_clamp();
        par_write(32'h8000_0005);
        chk("R9 code 5 clamped", {22'd0, dac_code}, 32'd204);
        par_write(32'h8000_00CB);
        chk("R9 code 203 clamped", {22'd0, dac_code}, 32'd204);
        par_write(32'h8000_00CD);
        chk("R9 code 205 passes", {22'd0, dac_code}, 32'd205);
    endtask

    task automatic t_collision();
        strobe(16'h8000);
        @(negedge clk) wr_data = 16'h0123; wr_stb = 1'b1; conv_start = 1'b1;
        @(negedge clk) wr_stb = 1'b0; conv_start = 1'b0;
        @(negedge clk);
        chk("R8 same-cycle start, word applied", {22'd0, dac_code}, 32'h123);
        chk("R8 same-cycle start, no error", {31'd0, abort_err}, 32'd0);
    endtask

    task automatic t_abort();
        strobe(16'h8000);
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk) conv_start = 1'b0;
        strobe(16'h0077);
        @(negedge clk);
        chk("R8 aborted pair no change", {22'd0, dac_code}, 32'h123);
        chk("R8 error set", {31'd0, abort_err}, 32'd1);
        strobe(16'h0000);
        par_write(32'h8000_0200);
        chk("R8 later pair works", {22'd0, dac_code}, 32'h200);
        chk("R8 error sticky", {31'd0, abort_err}, 32'd1);
    endtask

    task automatic t_reset_again();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parallel();
        t_no_wen();
        t_serial();
        t_readback();
        t_hw_mode();
        t_clamp();
        t_collision();
        t_abort();
        t_reset_again();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule